// File: doc/BRIEF.md
# Three-Wire Serial Register Write Master

This block drives write transactions toward a serial register-array slave over three lines: a frame strobe that idles high and goes low for the length of a transfer, a serial clock, and a serial data line. A host hands it one request at a time, made of a data byte and a 6-bit row address, through a valid/ready handshake. The block builds an 18-bit frame and shifts it out least significant bit first, one bit per clock pulse, then raises the strobe so that the slave commits the row.

All line timing is set in system clock cycles by five count inputs: data setup before each rising clock edge, clock high time, data hold after each falling clock edge, the clock-low interval before the strobe is released, and the minimum strobe-high gap before the next frame may start. A count of zero acts as one. The counts are read live and must be held steady while a frame is in flight. A single-cycle done pulse closes each transfer.

Top module: `srl_wr_master`

## Requirements
- R1: When idle, after reset and between frames, strobe_o is 1, sclk_o is 0, sdata_o is 0, req_ready_o is 1 and done_o is 0.
- R2: A request is taken on a rising edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after that edge until done_o is pulsed. done_o is high for exactly one cycle, and req_ready_o is 1 in that cycle.
- R3: On the edge that accepts a request, strobe_o falls and frame bit 0 appears on sdata_o in the same cycle.
- R4: Every frame has exactly 18 rising edges of sclk_o. Serial bit k, counted from 0, is as follows: bits 0 to 7 are req_data_i, LSB first. Bits 8 to 13 are req_addr_i, LSB first. Bit 14 is the write flag, value 1. Bits 15 to 17 are the chip identifier, default value 6 (binary 110), LSB first, so the line carries 0, 1, 1.
- R5: Before every rising edge of sclk_o, the line sits low with strobe_o low. This lasts cfg_setup_i cycles before the first edge and cfg_hold_i + cfg_setup_i cycles between pulses. sdata_o does not change on the rising edge.
- R6: sclk_o stays high for exactly cfg_high_i cycles per pulse, and sdata_o is constant while it is high.
- R7: After each falling edge of sclk_o, sdata_o keeps its value for cfg_hold_i cycles. Any change of sdata_o within a frame happens exactly cfg_hold_i cycles after a falling edge.
- R8: After the 18th falling edge, sclk_o stays low with strobe_o low for cfg_hold_i + cfg_release_i cycles before strobe_o rises.
- R9: strobe_o is high for exactly cfg_gap_i cycles before done_o is pulsed.
- R10: A count input of 0 gives the same timing as a value of 1.
- R11: A req_valid_i pulse while req_ready_o is 0 is ignored. No extra frame follows, and the lines stay idle after done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Write request valid |
| req_ready_o | output | 1 | Ready to accept a request |
| req_data_i | input | DATA_W (8) | Row data byte |
| req_addr_i | input | ADDR_W (6) | Row address |
| cfg_setup_i | input | CNT_W (8) | Data setup cycles before each rising clock edge |
| cfg_high_i | input | CNT_W (8) | Serial clock high cycles |
| cfg_hold_i | input | CNT_W (8) | Data hold cycles after each falling clock edge |
| cfg_release_i | input | CNT_W (8) | Extra clock-low cycles before strobe release |
| cfg_gap_i | input | CNT_W (8) | Strobe-high cycles before completion |
| done_o | output | 1 | One-cycle completion pulse |
| strobe_o | output | 1 | Frame strobe, low during a transfer |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |

## Verification
A wrong shift register or bit counter shows up as a misplaced or missing bit, or as a pulse count other than 18. This is visible at the latest when strobe_o rises, one frame after the fault. A wrong phase timer shows up as a low or high run of the wrong length on sclk_o, measured at the very next clock edge, or as a gap of the wrong length before done_o. A wrong state after completion shows up as a stray frame or as a data line left high in idle, within a few cycles of done_o.

// File: rtl/srl_wr_pkg.sv
package srl_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD,
    ST_RELEASE,
    ST_GAP
  } wr_state_e;

endpackage

// File: rtl/srl_wr_timer.sv
// Phase timer: a load of N (0 treated as 1) expires after exactly N cycles.
module srl_wr_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

  // R10: a zero-length load behaves as a one-cycle phase
  p_zero_len_r10: assert property (@(posedge clk) disable iff (rst)
    (load_i && len_i == '0) |=> expired_o);

  // R10: a longer load cannot expire in the next cycle
  p_long_len_r10: assert property (@(posedge clk) disable iff (rst)
    (load_i && len_i > 1) |=> !expired_o);

endmodule

// File: rtl/srl_wr_frame.sv
// Frame shifter: builds {id, write flag, addr, data} and shifts it LSB first.
module srl_wr_frame #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int ID_W    = 3,
  parameter int CHIP_ID = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              bit_o
);

  localparam int FRAME_W = DATA_W + ADDR_W + 1 + ID_W;
  localparam logic [ID_W-1:0] ID_VAL = ID_W'(CHIP_ID);

  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
    end else if (load_i) begin
      sreg_q <= {ID_VAL, 1'b1, addr_i, data_i};
    end else if (shift_i) begin
      sreg_q <= {1'b0, sreg_q[FRAME_W-1:1]};
    end else if (clear_i) begin
      sreg_q <= '0;
    end
  end

  assign bit_o = sreg_q[0];

  // R3: data LSB is on the line right after loading
  p_load_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (bit_o == $past(data_i[0])));

  // R1: clearing leaves the line low
  p_clear_low_r1: assert property (@(posedge clk) disable iff (rst)
    (clear_i && !load_i) |=> !bit_o);

endmodule

// File: rtl/srl_wr_master.sv
module srl_wr_master #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter int ID_W    = 3,
  parameter int CHIP_ID = 6,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  cfg_setup_i,
  input  logic [CNT_W-1:0]  cfg_high_i,
  input  logic [CNT_W-1:0]  cfg_hold_i,
  input  logic [CNT_W-1:0]  cfg_release_i,
  input  logic [CNT_W-1:0]  cfg_gap_i,
  output logic              done_o,
  output logic              strobe_o,
  output logic              sclk_o,
  output logic              sdata_o
);
  import srl_wr_pkg::*;

  localparam int FRAME_W = DATA_W + ADDR_W + 1 + ID_W;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

  wr_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_len;
  logic             frm_load, frm_shift, frm_clear;
  logic             done_d;
  logic             strobe_q, sclk_q, ready_q, done_q;

  srl_wr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .len_i     (tmr_len),
    .expired_o (tmr_exp)
  );

  srl_wr_frame #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W),
    .CHIP_ID (CHIP_ID)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .load_i  (frm_load),
    .shift_i (frm_shift),
    .clear_i (frm_clear),
    .data_i  (req_data_i),
    .addr_i  (req_addr_i),
    .bit_o   (sdata_o)
  );

  always_comb begin
    state_d   = state_q;
    bit_d     = bit_q;
    tmr_load  = 1'b0;
    tmr_len   = '0;
    frm_load  = 1'b0;
    frm_shift = 1'b0;
    frm_clear = 1'b0;
    done_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i && ready_q) begin
          state_d  = ST_SETUP;
          bit_d    = '0;
          tmr_load = 1'b1;
          tmr_len  = cfg_setup_i;
          frm_load = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          state_d  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_len  = cfg_high_i;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = cfg_hold_i;
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (bit_q == LAST_BIT) begin
            state_d = ST_RELEASE;
            tmr_len = cfg_release_i;
          end else begin
            state_d   = ST_SETUP;
            tmr_len   = cfg_setup_i;
            frm_shift = 1'b1;
            bit_d     = bit_q + 1'b1;
          end
        end
      end
      ST_RELEASE: begin
        if (tmr_exp) begin
          state_d   = ST_GAP;
          tmr_load  = 1'b1;
          tmr_len   = cfg_gap_i;
          frm_clear = 1'b1;
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      strobe_q <= 1'b1;
      sclk_q   <= 1'b0;
      ready_q  <= 1'b1;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      strobe_q <= (state_d == ST_IDLE) || (state_d == ST_GAP);
      sclk_q   <= (state_d == ST_HIGH);
      ready_q  <= (state_d == ST_IDLE);
      done_q   <= done_d;
    end
  end

  assign req_ready_o = ready_q;
  assign done_o      = done_q;
  assign strobe_o    = strobe_q;
  assign sclk_o      = sclk_q;

  // R1: the clock never pulses while the strobe is high
  p_clk_low_idle_r1: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> !sclk_o);

  // R1: data line is low whenever the block is ready
  p_idle_data_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready_o |-> !sdata_o);

  // R2: acceptance drops ready
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R2: done is a single-cycle pulse with ready up
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_ready_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> req_ready_o);

  // R4: bit index stays inside the frame
  p_bit_range_r4: assert property (@(posedge clk) disable iff (rst)
    bit_q <= LAST_BIT);

  // R5: data is stable across each rising clock edge
  p_setup_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(sdata_o));

  // R7: data is stable across each falling clock edge
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> $stable(sdata_o));

  // R8: the strobe rises only after the clock has been low
  p_release_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_o) |-> (!sclk_o && !$past(sclk_o)));

endmodule

// File: tb/srl_wr_master_tb.sv
module srl_wr_master_tb;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [7:0]    req_data  = '0;
  logic [5:0]    req_addr  = '0;
  logic [CW-1:0] c_s = 8'd1, c_h = 8'd1, c_d = 8'd1, c_r = 8'd1, c_g = 8'd1;
  logic          ready, done, strobe, sclk, sdata;

  int n_chk = 0;
  int n_bad = 0;

  srl_wr_master u_dut (
    .clk           (clk),
    .rst           (rst),
    .req_valid_i   (req_valid),
    .req_ready_o   (ready),
    .req_data_i    (req_data),
    .req_addr_i    (req_addr),
    .cfg_setup_i   (c_s),
    .cfg_high_i    (c_h),
    .cfg_hold_i    (c_d),
    .cfg_release_i (c_r),
    .cfg_gap_i     (c_g),
    .done_o        (done),
    .strobe_o      (strobe),
    .sclk_o        (sclk),
    .sdata_o       (sdata)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check_idle(input string tag);
    check(strobe && !sclk && !sdata && ready && !done, tag,
          {strobe, sclk, sdata, ready, done}, 5'b10010);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [5:0] a,
                           input int s, input int h, input int hd,
                           input int r, input int g, input bit poke);
    int es, eh, ed, er, eg;
    logic [17:0] expf;
    logic [17:0] got;
    int pulses, lowrun, highrun, gaprun, rel, guard;
    bit bad_setup, bad_high, bad_hold, bad_stable, bad_ready, fin, poked, stray_done;
    logic p_sclk, p_sdata, p_strobe;
    es = eff(s); eh = eff(h); ed = eff(hd); er = eff(r); eg = eff(g);
    expf = {3'b110, 1'b1, a, d};
    got = '0; pulses = 0; highrun = 0; gaprun = 0; rel = -1; guard = 0;
    bad_setup = 0; bad_high = 0; bad_hold = 0; bad_stable = 0; bad_ready = 0;
    fin = 0; poked = 0; stray_done = 0;

    @(negedge clk);
    c_s = CW'(s); c_h = CW'(h); c_d = CW'(hd); c_r = CW'(r); c_g = CW'(g);
    req_data = d; req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    // R3: strobe falls with bit 0 already present
    check(!strobe && !sclk && (sdata == d[0]), "R3 frame start",
          {strobe, sdata}, {1'b0, d[0]});
    if (ready) bad_ready = 1;
    lowrun = 1;
    p_sclk = sclk; p_sdata = sdata; p_strobe = strobe;

    while (!fin && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (!sclk && !strobe) begin
        if (p_sclk) begin
          if (highrun != eh) bad_high = 1;
          if (sdata != p_sdata) bad_stable = 1;
          lowrun = 1;
        end else begin
          if (sdata != p_sdata && lowrun != ed) bad_hold = 1;
          lowrun++;
        end
      end else if (sclk) begin
        if (!p_sclk) begin
          if (lowrun != ((pulses == 0) ? es : ed + es)) bad_setup = 1;
          if (sdata != p_sdata) bad_stable = 1;
          if (pulses < 18) got[pulses] = sdata;
          pulses++;
          highrun = 1;
        end else begin
          highrun++;
          if (sdata != p_sdata) bad_stable = 1;
        end
      end else begin
        if (!p_strobe) begin
          rel = lowrun;
          gaprun = 0;
        end
        if (done) fin = 1;
        else gaprun++;
      end
      if (done && strobe === 1'b0) stray_done = 1;
      if (!fin && ready) bad_ready = 1;
      if (poke && pulses == 5 && !poked) begin
        req_valid = 1'b1;
        req_data  = ~d;
        poked     = 1;
      end else begin
        req_valid = 1'b0;
      end
      p_sclk = sclk; p_sdata = sdata; p_strobe = strobe;
    end

    check(fin, "R2 frame completes", guard, 0);
    check(pulses == 18, "R4 pulse count", pulses, 18);
    check(got == expf, "R4 frame bits", int'(got), int'(expf));
    check(!bad_setup, "R5 setup run", lowrun, es);
    check(!bad_high, "R6 high time", highrun, eh);
    check(!bad_hold && !bad_stable, "R7 hold/stability", int'(bad_hold), 0);
    check(rel == ed + er, "R8 release interval", rel, ed + er);
    check(gaprun == eg, "R9 strobe gap", gaprun, eg);
    check(!bad_ready && !stray_done && ready, "R2 ready/done", int'(bad_ready), 0);
    if (s == 0 || h == 0 || hd == 0 || r == 0 || g == 0)
      check(!bad_setup && !bad_high && rel == ed + er && gaprun == eg,
            "R10 zero count acts as one", rel, ed + er);
    @(negedge clk);
    check_idle("R1 idle after frame");
    if (poke) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check(strobe && !sclk && ready && !done, "R11 busy request ignored",
              {strobe, sclk, ready, done}, 4'b1010);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1 idle after reset");

    // exhaustive data sweep, all addresses covered, minimum timing
    for (int i = 0; i < 256; i++) begin
      run_frame(8'(i), 6'(i * 5), 1, 1, 1, 1, 1, 1'b0);
    end

    // timing sweep including zero counts (R10) and busy pokes (R11)
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 4; h++) begin
        for (int hd = 0; hd < 4; hd++) begin
          run_frame(8'hA5 ^ 8'(s * 16 + h * 4 + hd), 6'(s * 7 + hd),
                    s, h, hd, (s + h) % 4, (hd + 2) % 5, ((s + h + hd) % 3) == 0);
        end
      end
    end

    // longer release and gap
    run_frame(8'hFF, 6'h3F, 2, 3, 1, 7, 9, 1'b1);
    run_frame(8'h00, 6'h00, 5, 1, 4, 1, 12, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule